// File: doc/BRIEF.md
# Scalar Integer Three-Operand Execution Unit

This unit executes one scalar "three same" instruction per transaction. It takes a 32-bit instruction word and two 64-bit operands that the register file has already read. It pulls the register indices, opcode, size and pairing bit out of the word and sorts the encoding into one of three classes: executed, recognized but not implemented, or unallocated. For the executed class it produces a 64-bit result.

The executed operations are wrapping add and subtract, signed and unsigned greater-than, signed and unsigned greater-or-equal, equality, and a bit-test. Compare and test results are full-width masks. Each result comes with a write enable and two status flags. The register indices are always reported so that a downstream stage can route the write or the exception.

Transactions use a valid/ready handshake on both sides. The result is held in one output register.

Top module: `simd3s_exec`

## Requirements
- R1: The word is decoded as follows: destination index in bits 4:0, first source index in bits 9:5, opcode in bits 15:11, second source index in bits 20:16, size in bits 23:22 and the pairing bit U in bit 29. The three indices are reported unchanged on the outputs for every transaction. All other bits of the word have no effect.
- R2: Opcode 0x10 with size 3 returns A+B when U=0 and A-B when U=1. Both wrap modulo 2^64.
- R3: Opcode 0x6 with size 3 tests A>B. The test is signed when U=0 and unsigned when U=1.
- R4: Opcode 0x7 with size 3 tests A>=B. The test is signed when U=0 and unsigned when U=1.
- R5: Opcode 0x11 with size 3 tests A==B when U=1. When U=0 it tests whether (A AND B) is nonzero.
- R6: A true compare or test returns all 64 bits set, and a false one returns zero. Every executed operation asserts the write enable.
- R7: Opcodes 0x6, 0x7, 0x10 and 0x11 with a size other than 3 raise the unallocated flag.
- R8: Opcodes 0x1, 0x5, 0x8, 0x9, 0xA and 0xB raise the unsupported flag for any size. The two flags are never both set.
- R9: Opcode 0x16 raises the unsupported flag for size 1 or 2, and the unallocated flag for size 0 or 3.
- R10: For opcodes 0x18 to 0x1F, a 7-bit code is formed as {U, size[1], opcode}. The codes 0x1B, 0x1C, 0x1F, 0x3F, 0x5C, 0x5D, 0x7A, 0x7C and 0x7D raise the unsupported flag. Every other code raises the unallocated flag.
- R11: Every opcode not named in R2 to R10 raises the unallocated flag.
- R12: When either flag is set, the result is zero and the write enable is low.
- R13: The output becomes valid on the clock edge that accepts a transaction. Input ready is low while an output is held and output ready is low. A held output stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can accept a transaction |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 64 | First operand (A) |
| in_opb | input | 64 | Second operand (B) |
| out_valid | output | 1 | Result register holds a transaction |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result value or mask |
| out_rd | output | 5 | Destination index |
| out_rn | output | 5 | First source index |
| out_rm | output | 5 | Second source index |
| out_we | output | 1 | Result is to be written |
| out_unalloc | output | 1 | Encoding is unallocated |
| out_unsupp | output | 1 | Encoding is recognized but not executed |

## Verification
Every outcome, including the flags, the indices and the result, is due one clock edge after the handshake is accepted, and it stays unchanged for as long as out_ready is low. The bench drives stimulus and samples outputs on the falling edge. It keeps a queue of expected transactions from the requirements, pushing an entry when in_valid and in_ready are both high and popping it when out_valid and out_ready are both high. At every falling edge it checks that out_valid agrees with whether the queue holds an entry, and it compares the held output with the queue head. Stalls are injected randomly, so held outputs are compared over several cycles in a row.

// File: rtl/simd3s_exec.sv
module simd3s_exec #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_insn,
  input  logic [DW-1:0] in_opa,
  input  logic [DW-1:0] in_opb,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [4:0]    out_rd,
  output logic [4:0]    out_rn,
  output logic [4:0]    out_rm,
  output logic          out_we,
  output logic          out_unalloc,
  output logic          out_unsupp
);

  wire [4:0] opc  = in_insn[15:11];
  wire [1:0] sz   = in_insn[23:22];
  wire       u    = in_insn[29];
  wire [6:0] fpc  = {u, sz[1], opc};

  logic unalloc_c, unsupp_c, cmp_c, run_c;

  always_comb begin
    unalloc_c = 1'b0;
    unsupp_c  = 1'b0;
    cmp_c     = 1'b0;
    if (opc >= 5'h18) begin
      case (fpc)
        7'h1B, 7'h1C, 7'h1F, 7'h3F, 7'h5C,
        7'h5D, 7'h7A, 7'h7C, 7'h7D: unsupp_c = 1'b1;
        default:                     unalloc_c = 1'b1;
      endcase
    end else begin
      case (opc)
        5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B: unsupp_c = 1'b1;
        5'h16: begin
          unsupp_c  = (sz == 2'd1) || (sz == 2'd2);
          unalloc_c = !unsupp_c;
        end
        5'h06, 5'h07, 5'h11: begin
          cmp_c     = 1'b1;
          unalloc_c = (sz != 2'd3);
        end
        5'h10:   unalloc_c = (sz != 2'd3);
        default: unalloc_c = 1'b1;
      endcase
    end
  end

  assign run_c = !unalloc_c && !unsupp_c;

  wire gt_s  = $signed(in_opa) >  $signed(in_opb);
  wire gt_u  = in_opa >  in_opb;
  wire ge_s  = $signed(in_opa) >= $signed(in_opb);
  wire ge_u  = in_opa >= in_opb;
  wire eq    = in_opa == in_opb;
  wire tst   = |(in_opa & in_opb);

  logic          cond;
  logic [DW-1:0] arith;
  logic [DW-1:0] res_c;

  always_comb begin
    case (opc)
      5'h06:   cond = u ? gt_u : gt_s;
      5'h07:   cond = u ? ge_u : ge_s;
      default: cond = u ? eq   : tst;
    endcase
  end

  assign arith = u ? (in_opa - in_opb) : (in_opa + in_opb);
  assign res_c = !run_c ? '0 : cmp_c ? {DW{cond}} : arith;

  wire take = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_rn      <= '0;
      out_rm      <= '0;
      out_we      <= 1'b0;
      out_unalloc <= 1'b0;
      out_unsupp  <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= res_c;
        out_rd      <= in_insn[4:0];
        out_rn      <= in_insn[9:5];
        out_rm      <= in_insn[20:16];
        out_we      <= run_c;
        out_unalloc <= unalloc_c;
        out_unsupp  <= unsupp_c;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/simd3s_exec_chk.sv
module simd3s_exec_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [31:0]   in_insn,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_we,
  input logic          out_unalloc,
  input logic          out_unsupp
);

  wire acc = in_valid && in_ready;

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R13

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_we)); // R13

  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R13

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_unalloc || out_unsupp) |-> out_result == '0 && !out_we); // R12

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_unalloc && out_unsupp)); // R8

  AST_GT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_insn[15:11] == 5'h06 && in_insn[23:22] == 2'd3
    |=> out_we && (out_result == '0 || out_result == '1)); // R6

  AST_SIZE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_insn[15:11] == 5'h10 && in_insn[23:22] != 2'd3 |=> out_unalloc); // R7

endmodule

bind simd3s_exec simd3s_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_we(out_we),
  .out_unalloc(out_unalloc), .out_unsupp(out_unsupp)
);

// File: tb/simd3s_exec_bench.sv
`timescale 1ns/1ps
module simd3s_exec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [4:0]  out_rd, out_rn, out_rm;
  logic        out_we, out_unalloc, out_unsupp;

  always #4 clk = ~clk;

  simd3s_exec u_simd3s_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm), .out_we(out_we),
    .out_unalloc(out_unalloc), .out_unsupp(out_unsupp)
  );

  typedef struct packed {
    logic [63:0] res;
    logic        we, ua, us;
    logic [4:0]  rd, rn, rm;
    logic [4:0]  opc;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  function automatic exp_t model(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    exp_t e;
    logic [4:0] op = w[15:11];
    logic [1:0] sz = w[23:22];
    logic       uu = w[29];
    logic [6:0] code = {uu, sz[1], op};
    longint sa = a, sb = b;
    bit t;
    e = '0;
    e.rd = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16]; e.opc = op;
    if (op >= 5'h18) begin
      if (code inside {7'h1B, 7'h1C, 7'h1F, 7'h3F, 7'h5C, 7'h5D, 7'h7A, 7'h7C, 7'h7D})
        e.us = 1; else e.ua = 1;
    end else if (op inside {5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B}) e.us = 1;
    else if (op == 5'h16) begin
      if (sz == 1 || sz == 2) e.us = 1; else e.ua = 1;
    end else if (op inside {5'h06, 5'h07, 5'h10, 5'h11}) begin
      if (sz != 3) e.ua = 1;
      else begin
        e.we = 1;
        if (op == 5'h10) e.res = uu ? a - b : a + b;
        else begin
          if (op == 5'h06)      t = uu ? (a > b) : (sa > sb);
          else if (op == 5'h07) t = uu ? (a >= b) : (sa >= sb);
          else                  t = uu ? (a == b) : ((a & b) != 0);
          e.res = t ? '1 : '0;
        end
      end
    end else e.ua = 1;
    return e;
  endfunction

  function automatic string tag_of(exp_t e);
    if (e.ua || e.us) return "R12";
    case (e.opc)
      5'h10:   return "R2";
      5'h06:   return "R3";
      5'h07:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string flag_tag(exp_t e);
    if (e.opc >= 5'h18) return "R10";
    if (e.opc == 5'h16) return "R9";
    if (e.opc inside {5'h06, 5'h07, 5'h10, 5'h11}) return "R7";
    if (e.us) return "R8";
    return "R11";
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(bit uu, logic [1:0] sz, logic [4:0] op);
    logic [31:0] w = $urandom;
    w[29] = uu; w[23:22] = sz; w[15:11] = op;
    return w;
  endfunction

  task automatic step(bit v, logic [31:0] w, logic [63:0] a, logic [63:0] b, bit rdy);
    exp_t e;
    @(negedge clk);
    check(out_valid == (q.size() > 0), "R13", 64'(out_valid), 64'(q.size() > 0));
    if (out_valid && q.size() > 0) begin
      e = q[0];
      check(out_result == e.res, tag_of(e), out_result, e.res);
      check(out_we == e.we, "R6", 64'(out_we), 64'(e.we));
      check({out_unalloc, out_unsupp} == {e.ua, e.us}, flag_tag(e),
            64'({out_unalloc, out_unsupp}), 64'({e.ua, e.us}));
      check({out_rd, out_rn, out_rm} == {e.rd, e.rn, e.rm}, "R1",
            64'({out_rd, out_rn, out_rm}), 64'({e.rd, e.rn, e.rm}));
    end
    in_valid = v; in_insn = w; in_opa = a; in_opb = b; out_ready = rdy;
    #1;
    if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
    if (in_valid && in_ready) q.push_back(model(in_insn, in_opa, in_opb));
  endtask

  localparam logic [63:0] MIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  initial begin
    repeat (3) @(negedge clk);
    // reset state R13
    check(out_valid == 0 && out_we == 0 && out_result == 0, "R13", 64'(out_valid), 0);
    rst_n = 1'b1;
    step(1, mk(0, 3, 5'h10), ONES, 64'd1, 1);      // R2 wrap add
    step(1, mk(1, 3, 5'h10), 64'd0, 64'd1, 1);     // R2 wrap sub
    step(1, mk(0, 3, 5'h06), MIN, 64'd1, 1);       // R3 signed false
    step(1, mk(1, 3, 5'h06), MIN, 64'd1, 1);       // R3 unsigned true
    step(1, mk(0, 3, 5'h07), 64'd5, 64'd5, 1);     // R4 equal
    step(1, mk(1, 3, 5'h07), 64'd4, 64'd5, 1);     // R4 less
    step(1, mk(0, 3, 5'h07), ONES, 64'd0, 1);      // R4 signed -1 < 0
    step(1, mk(1, 3, 5'h11), 64'h1234, 64'h1234, 1); // R5 eq
    step(1, mk(0, 3, 5'h11), 64'hF0, 64'h0F, 1);   // R5 test zero
    step(1, mk(0, 3, 5'h11), MIN, ONES, 1);        // R5 test nonzero
    step(1, mk(0, 2, 5'h10), 64'd1, 64'd2, 1);     // R7
    step(1, mk(1, 0, 5'h06), 64'd1, 64'd2, 1);     // R7
    step(1, mk(0, 3, 5'h01), 64'd1, 64'd2, 1);     // R8
    step(1, mk(1, 1, 5'h0B), 64'd1, 64'd2, 1);     // R8
    step(1, mk(0, 1, 5'h16), 64'd1, 64'd2, 1);     // R9 unsupported
    step(1, mk(0, 3, 5'h16), 64'd1, 64'd2, 1);     // R9 unallocated
    step(1, mk(0, 0, 5'h1B), 64'd1, 64'd2, 1);     // R10 code 0x1B
    step(1, mk(1, 0, 5'h1C), 64'd1, 64'd2, 1);     // R10 code 0x5C
    step(1, mk(1, 2, 5'h1A), 64'd1, 64'd2, 1);     // R10 code 0x7A
    step(1, mk(0, 2, 5'h1B), 64'd1, 64'd2, 1);     // R10 code 0x3B unalloc
    step(1, mk(0, 0, 5'h18), 64'd1, 64'd2, 1);     // R10 unalloc
    step(1, mk(0, 3, 5'h02), 64'd1, 64'd2, 1);     // R11
    step(1, mk(1, 3, 5'h17), 64'd1, 64'd2, 1);     // R11
    // stall: R13 hold and backpressure
    step(1, mk(0, 3, 5'h10), 64'd7, 64'd8, 0);
    step(1, mk(1, 3, 5'h10), 64'd9, 64'd3, 0);
    step(1, mk(1, 3, 5'h10), 64'd9, 64'd3, 0);
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      logic [63:0] a, b;
      op = (i % 3 == 0) ? 5'($urandom) :
           5'({5'h06, 5'h07, 5'h10, 5'h11}[($urandom % 4) * 5 +: 5]);
      a = {$urandom, $urandom};
      b = (i % 5 == 0) ? a : {$urandom, $urandom};
      if (i % 7 == 0) a[63] = ~b[63];
      step(($urandom % 4) != 0, mk(1'($urandom), (i % 4 == 0) ? 2'($urandom) : 2'd3, op),
           a, b, ($urandom % 3) != 0);
    end
    step(0, '0, '0, '0, 1);
    step(0, '0, '0, '0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R13: watchdog expired, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule